// File: doc/BRIEF.md
# Early Receive Event Interrupt Generator

This block follows an incoming Ethernet receive byte stream and tells the host about a frame before the whole frame has arrived. A start-of-frame strobe opens a frame and clears a saturating byte counter. Per-byte strobes advance the counter. A pass flag from an external destination-address filter arms an address event, and an end-of-frame strobe closes the frame.

The block keeps a 16-bit buffer-event status word and a 16-bit interrupt-enable word. The host reads the status word with a read-to-clear strobe. It writes the enable word through a plain write port. Three event bits are implemented:

| Bit | Event | Enable bit |
|-----|-------|------------|
| 15 | Address event | 15 |
| 11 | Early-length event | 11 |
| 8 | Frame-done event | 8 |

The two early events are also retired by the hardware as the frame moves on. The frame-done event leaves only through a host read. One interrupt line is driven. A read-window output tells the host how many leading bytes of the frame it may already read.

Top module: `early_rx_irq`

## Requirements
- R1: Bit 15 of the status word sets one cycle after a cycle in which a frame is open, no start or end strobe is present, the pass flag is high, at least DA_BYTES bytes have been counted and the early-length point has not yet been reached. It sets at most once per frame; a host read within the frame does not re-arm it.
- R2: Bit 11 sets in the same clock edge that counts byte number EARLY_BYTES of the frame, and that same edge clears bit 15.
- R3: A frame that closes with fewer than EARLY_BYTES bytes never sets bit 11. A pass flag seen before DA_BYTES bytes are counted is ignored.
- R4: An end-of-frame strobe in an open frame clears bit 11 and sets bit 8 at the next edge. Bit 15 is left unchanged by it.
- R5: A host read strobe returns the current status word and clears every event bit at the next edge. A hardware set in the same cycle wins over that clear.
- R6: The interrupt line is high exactly when some bit among 15, 11 and 8 is set in both the status word and the enable word. The enable word keeps only bits 15, 11 and 8 of a write; all other bits read as 0.
- R7: The read window is 0 after start-of-frame. It becomes DA_BYTES when bit 15 sets and EARLY_BYTES when bit 11 sets. At end-of-frame it becomes the frame's byte count.
- R8: The byte counter saturates at MAX_BYTES, so the read window after end-of-frame never exceeds MAX_BYTES.
- R9: After reset the status word, enable word, interrupt line and read window are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe |
| byte_vld_i | input | 1 | One received byte this cycle |
| da_pass_i | input | 1 | Destination-address filter pass flag |
| eof_i | input | 1 | End-of-frame strobe |
| host_rd_i | input | 1 | Read-to-clear strobe for the status word |
| host_wr_i | input | 1 | Write strobe for the enable word |
| host_wdata_i | input | 16 | Enable word write data |
| evt_rdata_o | output | 16 | Current status word |
| cfg_rdata_o | output | 16 | Current enable word |
| irq_o | output | 1 | Interrupt request |
| rd_window_o | output | CNT_W | Number of leading bytes the host may read |

## Verification
The bench builds the block with DA_BYTES=6, EARLY_BYTES=16 and MAX_BYTES=40. Those values put the early-length point and the saturation limit within a few dozen bytes. This lets the bench sweep every frame length from 0 to 45 against several pass-flag arrival points. The sweep covers frames that end before the address sample point, between the two early points, exactly at and beyond the early-length point, and beyond the cap. Targeted runs cover collisions of host reads with hardware sets. An enable sweep covers all combinations of the three enable bits over two status patterns.

// File: rtl/erx_pkg.sv
package erx_pkg;
  localparam int unsigned EVW      = 16;
  localparam int unsigned BIT_DA   = 15;
  localparam int unsigned BIT_ERLY = 11;
  localparam int unsigned BIT_DONE = 8;

  typedef logic [EVW-1:0] evt_word_t;

  typedef struct packed {
    logic da;
    logic early;
    logic done;
  } evt_set_t;

  // Bits that exist in both the status and the enable word.
  function automatic evt_word_t impl_mask();
    evt_word_t m;
    m = '0;
    m[BIT_DA]   = 1'b1;
    m[BIT_ERLY] = 1'b1;
    m[BIT_DONE] = 1'b1;
    return m;
  endfunction

  // Next status word: host clear first, then hardware sets and retirements.
  function automatic evt_word_t evt_next(input evt_word_t cur, input logic rd,
                                         input evt_set_t s);
    evt_word_t n;
    n = rd ? '0 : cur;
    if (s.da)    n[BIT_DA] = 1'b1;
    if (s.early) begin
      n[BIT_ERLY] = 1'b1;
      n[BIT_DA]   = 1'b0;
    end
    if (s.done) begin
      n[BIT_DONE] = 1'b1;
      n[BIT_ERLY] = 1'b0;
    end
    return n;
  endfunction
endpackage

// File: rtl/erx_frame_track.sv
module erx_frame_track #(
  parameter int unsigned MAX_BYTES   = 1518,
  parameter int unsigned DA_BYTES    = 6,
  parameter int unsigned EARLY_BYTES = 128,
  parameter int unsigned CNT_W       = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             byte_vld_i,
  input  logic             da_pass_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             in_frame_o,
  output erx_pkg::evt_set_t set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             in_frame_q, da_seen_q, hit_early_q;
  logic             mid_frame, byte_ok;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c >= CNT_W'(MAX_BYTES)) ? c : c + 1'b1;
  endfunction

  assign mid_frame = in_frame_q && !sof_i && !eof_i;
  assign byte_ok   = mid_frame && byte_vld_i;

  always_comb begin
    set_o.early = byte_ok && (cnt_q == CNT_W'(EARLY_BYTES - 1));
    set_o.da    = mid_frame && da_pass_i && !da_seen_q && !hit_early_q &&
                  (cnt_q >= CNT_W'(DA_BYTES));
    set_o.done  = in_frame_q && eof_i && !sof_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      in_frame_q  <= 1'b0;
      da_seen_q   <= 1'b0;
      hit_early_q <= 1'b0;
    end else if (sof_i) begin
      cnt_q       <= '0;
      in_frame_q  <= 1'b1;
      da_seen_q   <= 1'b0;
      hit_early_q <= 1'b0;
    end else begin
      if (byte_ok)     cnt_q       <= sat_inc(cnt_q);
      if (set_o.da)    da_seen_q   <= 1'b1;
      if (set_o.early) hit_early_q <= 1'b1;
      if (set_o.done)  in_frame_q  <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign in_frame_o = in_frame_q;

  p_cnt_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_BYTES));
  p_no_count_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame_q && !sof_i) |=> $stable(cnt_q));
endmodule

// File: rtl/erx_event_regs.sv
module erx_event_regs (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_rd_i,
  input  logic                host_wr_i,
  input  erx_pkg::evt_word_t  host_wdata_i,
  input  erx_pkg::evt_set_t   set_i,
  output erx_pkg::evt_word_t  evt_o,
  output erx_pkg::evt_word_t  cfg_o,
  output logic                irq_o
);
  import erx_pkg::*;
  evt_word_t evt_q, cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      cfg_q <= '0;
    end else begin
      evt_q <= evt_next(evt_q, host_rd_i, set_i);
      if (host_wr_i) cfg_q <= host_wdata_i & impl_mask();
    end
  end

  assign evt_o = evt_q;
  assign cfg_o = cfg_q;
  assign irq_o = |(evt_q & cfg_q);

  p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !set_i.da && !set_i.early && !set_i.done) |=> (evt_q == '0));
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && set_i.done) |=> evt_q[BIT_DONE]);
  p_early_drops_da_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i.early |=> (evt_q[BIT_ERLY] && !evt_q[BIT_DA]));
  p_eof_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i.done |=> (evt_q[BIT_DONE] && !evt_q[BIT_ERLY]));
  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q & ~impl_mask()) == '0) && ((evt_q & ~impl_mask()) == '0));
endmodule

// File: rtl/erx_read_window.sv
module erx_read_window #(
  parameter int unsigned DA_BYTES    = 6,
  parameter int unsigned EARLY_BYTES = 128,
  parameter int unsigned CNT_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  erx_pkg::evt_set_t set_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  win_o
);
  logic [CNT_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            win_q <= '0;
    else if (sof_i)        win_q <= '0;
    else if (set_i.early)  win_q <= CNT_W'(EARLY_BYTES);
    else if (set_i.da)     win_q <= CNT_W'(DA_BYTES);
    else if (set_i.done)   win_q <= cnt_i;
  end

  assign win_o = win_q;

  p_win_on_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i.early |=> (win_q == CNT_W'(EARLY_BYTES)));
endmodule

// File: rtl/early_rx_irq.sv
module early_rx_irq #(
  parameter int unsigned MAX_BYTES   = 1518,
  parameter int unsigned DA_BYTES    = 6,
  parameter int unsigned EARLY_BYTES = 128,
  localparam int unsigned CNT_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  input  logic             da_pass_i,
  input  logic             eof_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  input  logic [15:0]      host_wdata_i,
  output logic [15:0]      evt_rdata_o,
  output logic [15:0]      cfg_rdata_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] rd_window_o
);
  import erx_pkg::*;

  logic [CNT_W-1:0] byte_cnt;
  logic             in_frame;
  evt_set_t         evt_set;
  evt_word_t        evt_w, cfg_w;

  erx_frame_track #(
    .MAX_BYTES(MAX_BYTES), .DA_BYTES(DA_BYTES),
    .EARLY_BYTES(EARLY_BYTES), .CNT_W(CNT_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .eof_i(eof_i),
    .byte_vld_i(byte_vld_i), .da_pass_i(da_pass_i),
    .cnt_o(byte_cnt), .in_frame_o(in_frame), .set_o(evt_set)
  );

  erx_event_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_rd_i(host_rd_i), .host_wr_i(host_wr_i),
    .host_wdata_i(host_wdata_i), .set_i(evt_set),
    .evt_o(evt_w), .cfg_o(cfg_w), .irq_o(irq_o)
  );

  erx_read_window #(
    .DA_BYTES(DA_BYTES), .EARLY_BYTES(EARLY_BYTES), .CNT_W(CNT_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .set_i(evt_set),
    .cnt_i(byte_cnt), .win_o(rd_window_o)
  );

  assign evt_rdata_o = evt_w;
  assign cfg_rdata_o = cfg_w;

  p_da_after_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_w[BIT_DA]) |-> (byte_cnt >= CNT_W'(DA_BYTES)));
  p_early_at_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_w[BIT_ERLY]) |-> (byte_cnt == CNT_W'(EARLY_BYTES)));
  p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_window_o <= byte_cnt);
  p_done_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_w[BIT_DONE]) |-> !in_frame);
endmodule

// File: tb/tb_early_rx_irq.sv
module tb_early_rx_irq;
  localparam int MAXB = 40;
  localparam int DAB  = 6;
  localparam int ERB  = 16;
  localparam int CW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, bv = 1'b0, pass = 1'b0, eof = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] evt, cfg;
  logic irq;
  logic [CW-1:0] win;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  early_rx_irq #(.MAX_BYTES(MAXB), .DA_BYTES(DAB), .EARLY_BYTES(ERB)) dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(bv), .da_pass_i(pass),
    .eof_i(eof), .host_rd_i(rd), .host_wr_i(wr), .host_wdata_i(wdata),
    .evt_rdata_o(evt), .cfg_rdata_o(cfg), .irq_o(irq), .rd_window_o(win)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected address-event state at the end of the byte phase.
  function automatic bit exp_da(input int len, input int da_at);
    return (len < ERB) && (len - 1 >= imax(da_at, DAB));
  endfunction

  task automatic open_frame();
    sof = 1'b1; cyc(); sof = 1'b0;
  endtask

  task automatic send_bytes(input int len, input int da_at, input int rd_at);
    for (int k = 0; k < len; k++) begin
      bv = 1'b1; pass = (k >= da_at); rd = (k == rd_at);
      cyc();
    end
    bv = 1'b0; pass = 1'b0; rd = 1'b0;
  endtask

  task automatic close_frame(input bit with_rd);
    eof = 1'b1; rd = with_rd; cyc(); eof = 1'b0; rd = 1'b0;
  endtask

  task automatic host_read();
    rd = 1'b1; cyc(); rd = 1'b0;
  endtask

  task automatic write_cfg(input logic [15:0] v);
    wr = 1'b1; wdata = v; cyc(); wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int das[7] = '{0, 3, 6, 7, 10, 15, 20};
    repeat (3) cyc();
    // R9 reset state
    chk("R9 evt", evt, 0);
    chk("R9 cfg", cfg, 0);
    chk("R9 irq", irq, 0);
    chk("R9 win", win, 0);
    rst_n = 1'b1;
    cyc();

    // Sweep lengths and pass arrival points: R1 R2 R3 R4 R5 R7 R8
    for (int len = 0; len <= 45; len++) begin
      foreach (das[i]) begin
        bit d;
        int wmid;
        d = exp_da(len, das[i]);
        open_frame();
        chk("R7 win after sof", win, 0);
        send_bytes(len, das[i], -1);
        wmid = (len >= ERB) ? ERB : (d ? DAB : 0);
        chk("R1 da bit mid", evt[15], d);
        chk("R2 R3 early bit mid", evt[11], (len >= ERB));
        chk("R7 win mid", win, wmid);
        close_frame(1'b0);
        chk("R4 evt after eof", evt, (d ? 16'h8000 : 0) | 16'h0100);
        chk("R8 win after eof", win, (len > MAXB) ? MAXB : len);
        host_read();
        chk("R5 evt cleared", evt, 0);
      end
    end

    // R2 R5: host read in the same cycle as the early-length set
    open_frame();
    send_bytes(ERB, 0, ERB - 1);
    chk("R5 early set wins over read", evt[11], 1);
    chk("R2 da cleared at early", evt[15], 0);
    // R4 R5: read together with end-of-frame
    close_frame(1'b1);
    chk("R5 done set wins over read", evt, 16'h0100);
    host_read();

    // R1 R5: read clears address event and it is not re-armed
    open_frame();
    send_bytes(9, 0, -1);
    chk("R1 da set", evt[15], 1);
    host_read();
    chk("R5 da cleared by read", evt[15], 0);
    send_bytes(3, 0, -1);
    chk("R1 da not re-armed", evt[15], 0);
    chk("R7 win held", win, DAB);
    close_frame(1'b0);
    chk("R4 da untouched by eof", evt, 16'h0100);
    chk("R7 win eof", win, 12);

    // R6: enable sweep over status 0x0100, then over 0x0800 mid-frame
    for (int c = 0; c < 8; c++) begin
      logic [15:0] v;
      v = {c[2], 3'b0, c[1], 2'b0, c[0], 8'h00};
      write_cfg(v | 16'h36F6 & ~16'h8900);
      chk("R6 cfg mask", cfg, v);
      chk("R6 irq done", irq, (v & 16'h0100) != 0);
    end
    host_read();
    open_frame();
    send_bytes(ERB + 2, 0, -1);
    for (int c = 0; c < 8; c++) begin
      logic [15:0] v;
      v = {c[2], 3'b0, c[1], 2'b0, c[0], 8'h00};
      write_cfg(v | 16'h4321 & ~16'h8900);
      chk("R6 irq early", irq, (v & 16'h0800) != 0);
    end
    close_frame(1'b0);
    write_cfg(16'h8000);
    chk("R6 irq no match", irq, 0);
    write_cfg(16'hFFFF);
    chk("R6 irq match", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule